// File: doc/BRIEF.md
# DMA Controller Command, Mask and Request Block

This block holds the controller-wide registers of a four-channel DMA controller: the command word, the channel mask, the status byte (request bits in the upper half, terminal-count bits in the lower half) and one mode byte per channel. The CPU reaches these registers through a four-bit port offset. Only offsets 8 to 15 belong to this block. Each offset has its own write action, and two offsets return data on a read.

A transfer engine that sits beside the block reports terminal count on a per-channel input. Request sources raise or drop a channel's request through separate hold and release inputs. The block presents a registered service-enable vector that tells the transfer engine which channels may run. It also gives one-cycle pulses for the byte flip-flop clear and for master reset, so that the neighbouring address and count logic can follow them.

Top module: `dma_ctl_regs`

## Requirements
- R1: A write to offset 8 loads the command word only when the data is zero or has no bit set except bit 2. Any other value leaves the command word unchanged.
- R2: A write to offset 9 selects a channel with data bits 1:0. It sets (data bit 2 = 1) or clears (bit 2 = 0) that channel's request bit, which is status bit channel+4. It always clears that channel's terminal-count bit, which is status bit channel.
- R3: A write to offset 0xA sets (data bit 2 = 1) or clears the mask bit of the channel given by data bits 1:0.
- R4: A write to offset 0xB stores the whole data byte as the mode of the channel given by data bits 1:0. The fields are: bits 7:6 operating mode, bit 5 address decrement, bit 4 auto-init, bits 3:2 transfer type. Channel n's mode appears on `mode_flat[8n+7:8n]`.
- R5: A write to offset 0xC raises `ff_clr_pulse` for exactly one cycle. A write to offset 0xD raises `mrst_pulse` for one cycle and sets the mask to all ones, the status to 0 and the command to 0. Mode bytes are kept.
- R6: A write to offset 0xE clears every mask bit. A write to offset 0xF loads mask bit n from data bit n.
- R7: A read of offset 8 puts the status byte on `rd_data` one cycle later and clears status bits 3:0. A read of 0xF returns the mask in bits 3:0 with zeros above. A read of any other offset returns 0.
- R8: `svc_en[n]` is 1 exactly one cycle after channel n has mask bit 0 and request bit 1.
- R9: `req_hold[n]` sets and `req_release[n]` clears request bit n. In the same cycle, hold wins over release, over an offset 9 write and over master reset.
- R10: `tc_done[n]` sets terminal-count bit n. In the same cycle it wins over every clear (status read, offset 9 write, master reset).
- R11: While `rst_n` is low at a clock edge, the mask becomes 1111 and the command, status, modes, `svc_en`, `rd_data` and both pulses become 0.
- R12: Writes to offsets 0 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Port offset |
| wr_data | input | 8 | Write data |
| req_hold | input | 4 | Per-channel external request set |
| req_release | input | 4 | Per-channel external request clear |
| tc_done | input | 4 | Per-channel terminal count from the transfer engine |
| rd_data | output | 8 | Registered read data |
| cmd_word | output | 8 | Current command word |
| mode_flat | output | 32 | Mode bytes, channel n in bits 8n+7:8n |
| svc_en | output | 4 | Registered per-channel service enable |
| ff_clr_pulse | output | 1 | One-cycle flip-flop clear pulse |
| mrst_pulse | output | 1 | One-cycle master reset pulse |

## Verification
A wrong mask or request bit shows on `svc_en` one cycle after the register edge. It also shows in a status or mask read, which returns the value on `rd_data` on the cycle after the read strobe. A terminal-count bit that is lost or cleared by mistake can only be seen through a status read, so the tests read status directly after each event that sets or clears it. This includes reads where the event and the read fall in the same cycle. A wrongly accepted command shows on `cmd_word` at once, and mode corruption shows on `mode_flat` in the cycle after the write.

// File: rtl/dma_ctl_pkg.sv
// Package: shared offsets, write-strobe bundle and command filter for the
// DMA control register block. Offsets are relative to the block base (8).
package dma_ctl_pkg;

    typedef enum logic [2:0] {
        OFS_CMD   = 3'd0,
        OFS_REQ   = 3'd1,
        OFS_SMASK = 3'd2,
        OFS_MODE  = 3'd3,
        OFS_FFCLR = 3'd4,
        OFS_MRST  = 3'd5,
        OFS_MCLR  = 3'd6,
        OFS_MLOAD = 3'd7
    } ctl_ofs_e;

    // One strobe per control offset; at most one is high in a cycle.
    typedef struct packed {
        logic cmd;
        logic req;
        logic smask;
        logic mode;
        logic ffclr;
        logic mrst;
        logic mclr;
        logic mload;
    } ctl_wstb_t;

    // Only this command bit may be set in an accepted command word.
    localparam logic [7:0] CMD_ALLOWED = 8'h04;

endpackage

// File: rtl/dma_ctl_decode.sv
// Module: dma_ctl_decode
// Turns the CPU strobes and port offset into one write strobe per control
// register and the two read selects. Assumes the control window is the upper
// half of the offset space (offset bit 3 set when AW = 4).
module dma_ctl_decode
    import dma_ctl_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    output ctl_wstb_t         wstb,
    output logic              rd_status,
    output logic              rd_mask
);
    localparam int HIW = AW - 3;
    localparam logic [HIW-1:0] WIN = HIW'(1);

    logic     hit;
    ctl_ofs_e ofs;

    assign hit = (addr[AW-1:3] == WIN);
    assign ofs = ctl_ofs_e'(addr[2:0]);

    // Write strobe per offset, only inside the control window.
    always_comb begin
        wstb       = '0;
        if (wr_en && hit) begin
            unique case (ofs)
                OFS_CMD:   wstb.cmd   = 1'b1;
                OFS_REQ:   wstb.req   = 1'b1;
                OFS_SMASK: wstb.smask = 1'b1;
                OFS_MODE:  wstb.mode  = 1'b1;
                OFS_FFCLR: wstb.ffclr = 1'b1;
                OFS_MRST:  wstb.mrst  = 1'b1;
                OFS_MCLR:  wstb.mclr  = 1'b1;
                OFS_MLOAD: wstb.mload = 1'b1;
            endcase
        end
    end

    // Read selects for the two readable offsets.
    assign rd_status = rd_en && hit && (ofs == OFS_CMD);
    assign rd_mask   = rd_en && hit && (ofs == OFS_MLOAD);

endmodule

// File: rtl/dma_ctl_chan.sv
// Module: dma_ctl_chan
// One channel's slice: mask bit, request bit, terminal-count bit, mode byte
// and the registered service enable. Assumes channel select sits in data bits
// SELW-1:0 and the set/clear flag in the bit just above.
module dma_ctl_chan
    import dma_ctl_pkg::*;
#(
    parameter int CH_IDX = 0,
    parameter int SELW   = 2,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_wstb_t     wstb,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_status,
    input  logic          hold,
    input  logic          release_req,
    input  logic          tc_done,
    output logic          mask_q,
    output logic          req_q,
    output logic          tc_q,
    output logic [DW-1:0] mode_q,
    output logic          svc_q
);
    localparam int FLAG = SELW;
    localparam logic [SELW-1:0] MY_SEL = SELW'(CH_IDX);

    logic sel;
    logic mask_d, req_d, tc_d;

    assign sel = (wr_data[SELW-1:0] == MY_SEL);

    // Mask next value: master reset, clear-all, load-all, single set/clear.
    always_comb begin
        mask_d = mask_q;
        if (wstb.mrst)              mask_d = 1'b1;
        else if (wstb.mclr)         mask_d = 1'b0;
        else if (wstb.mload)        mask_d = wr_data[CH_IDX];
        else if (wstb.smask && sel) mask_d = wr_data[FLAG];
    end

    // Request next value: register write, then reset/release, hold last wins.
    always_comb begin
        req_d = req_q;
        if (wstb.req && sel)           req_d = wr_data[FLAG];
        if (wstb.mrst || release_req)  req_d = 1'b0;
        if (hold)                      req_d = 1'b1;
    end

    // Terminal-count next value: every clear source, then the set wins.
    always_comb begin
        tc_d = tc_q;
        if ((wstb.req && sel) || rd_status || wstb.mrst) tc_d = 1'b0;
        if (tc_done)                                     tc_d = 1'b1;
    end

    // Channel state registers and service enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            req_q  <= 1'b0;
            tc_q   <= 1'b0;
            mode_q <= '0;
            svc_q  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            req_q  <= req_d;
            tc_q   <= tc_d;
            if (wstb.mode && sel) mode_q <= wr_data;
            svc_q  <= !mask_q && req_q;
        end
    end

    AST_SVC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        svc_q |-> $past(!mask_q && req_q)); // R8
    AST_HOLD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> req_q); // R9
    AST_TC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tc_done |=> tc_q); // R10

endmodule

// File: rtl/dma_ctl_regs.sv
// Module: dma_ctl_regs (top)
// Controller-wide command, mask, status and mode registers of a DMA
// controller, with service enable and control pulses. Assumes 2*NUM_CH <= DW
// so status fits one read byte, and one CPU access per cycle.
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 4,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [NUM_CH-1:0]    req_hold,
    input  logic [NUM_CH-1:0]    req_release,
    input  logic [NUM_CH-1:0]    tc_done,
    output logic [DW-1:0]        rd_data,
    output logic [DW-1:0]        cmd_word,
    output logic [NUM_CH*DW-1:0] mode_flat,
    output logic [NUM_CH-1:0]    svc_en,
    output logic                 ff_clr_pulse,
    output logic                 mrst_pulse
);
    localparam int SELW = $clog2(NUM_CH);
    localparam int STW  = 2 * NUM_CH;

    ctl_wstb_t           wstb;
    logic                rd_status, rd_mask;
    logic [NUM_CH-1:0]   mask_vec, req_vec, tc_vec;
    logic [STW-1:0]      status_vec;
    logic                cmd_ok;

    dma_ctl_decode #(.AW(AW)) u_dec (
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wstb      (wstb),
        .rd_status (rd_status),
        .rd_mask   (rd_mask)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dma_ctl_chan #(.CH_IDX(ch), .SELW(SELW), .DW(DW)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wstb        (wstb),
            .wr_data     (wr_data),
            .rd_status   (rd_status),
            .hold        (req_hold[ch]),
            .release_req (req_release[ch]),
            .tc_done     (tc_done[ch]),
            .mask_q      (mask_vec[ch]),
            .req_q       (req_vec[ch]),
            .tc_q        (tc_vec[ch]),
            .mode_q      (mode_flat[ch*DW +: DW]),
            .svc_q       (svc_en[ch])
        );
    end

    assign status_vec = {req_vec, tc_vec};
    assign cmd_ok     = ((wr_data & ~CMD_ALLOWED) == '0);

    // Command word: accepted values only, cleared by master reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cmd_word <= '0;
        else if (wstb.mrst)          cmd_word <= '0;
        else if (wstb.cmd && cmd_ok) cmd_word <= wr_data;
    end

    // Read data capture: status, mask or zero for the addressed offset.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_data <= '0;
        else if (rd_status) rd_data <= DW'(status_vec);
        else if (rd_mask)   rd_data <= DW'(mask_vec);
        else if (rd_en)     rd_data <= '0;
    end

    // One-cycle control pulses for the neighbouring address/count logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_clr_pulse <= 1'b0;
            mrst_pulse   <= 1'b0;
        end else begin
            ff_clr_pulse <= wstb.ffclr;
            mrst_pulse   <= wstb.mrst;
        end
    end

    AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wstb.cmd && !cmd_ok) |=> $stable(cmd_word)); // R1
    AST_MRST_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        wstb.mrst |=> (mask_vec == '1 && cmd_word == '0)); // R5
    AST_STATUS_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && tc_done == '0) |=> (tc_vec == '0)); // R7
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ff_clr_pulse, mrst_pulse})); // R5

endmodule

// File: tb/tb_dma_ctl_regs.sv
`timescale 1ns/1ps
module tb_dma_ctl_regs;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [3:0]  addr;
    logic [7:0]  wr_data;
    logic [3:0]  req_hold, req_release, tc_done;
    logic [7:0]  rd_data, cmd_word;
    logic [31:0] mode_flat;
    logic [3:0]  svc_en;
    logic        ff_clr_pulse, mrst_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dma_ctl_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .req_hold(req_hold), .req_release(req_release),
        .tc_done(tc_done), .rd_data(rd_data), .cmd_word(cmd_word),
        .mode_flat(mode_flat), .svc_en(svc_en), .ff_clr_pulse(ff_clr_pulse),
        .mrst_pulse(mrst_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; addr = 0; wr_data = 0;
        req_hold = 0; req_release = 0; tc_done = 0;
    endtask

    // One cycle of stimulus, driven at a falling edge, released at the next.
    task automatic drive(input logic w, input logic r, input logic [3:0] a,
                         input logic [7:0] d, input logic [3:0] h,
                         input logic [3:0] rl, input logic [3:0] t);
        wr_en = w; rd_en = r; addr = a; wr_data = d;
        req_hold = h; req_release = rl; tc_done = t;
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        drive(1, 0, a, d, 0, 0, 0);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        drive(0, 1, a, 0, 0, 0, 0);
        v = rd_data;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R11 cmd", cmd_word, 0);
        chk("R11 svc", svc_en, 0);
        chk("R11 mode", mode_flat, 0);
        chk("R11 rd_data", rd_data, 0);
        chk("R11 pulses", {ff_clr_pulse, mrst_pulse}, 0);
        rd(4'h8, v); chk("R11 status", v, 8'h00);
        rd(4'hF, v); chk("R11 mask", v, 8'h0F);
    endtask

    task automatic t_command();
        logic [7:0] v;
        wr(4'h8, 8'h04); chk("R1 accept 04", cmd_word, 8'h04);
        wr(4'h8, 8'h05); chk("R1 reject 05", cmd_word, 8'h04);
        wr(4'h8, 8'h80); chk("R1 reject 80", cmd_word, 8'h04);
        wr(4'h8, 8'h00); chk("R1 accept 00", cmd_word, 8'h00);
        wr(4'h8, 8'h04);
        wr(4'h0, 8'h00); chk("R12 low offset cmd", cmd_word, 8'h04);
        wr(4'h7, 8'h00);
        rd(4'hF, v); chk("R12 low offset mask", v, 8'h0F);
    endtask

    task automatic t_mode();
        wr(4'hB, 8'h56);
        chk("R4 ch2 mode", mode_flat[23:16], 8'h56);
        wr(4'hB, 8'hA9);
        chk("R4 ch1 mode", mode_flat[15:8], 8'hA9);
        chk("R4 ch0/ch3 untouched", {mode_flat[31:24], mode_flat[7:0]}, 16'h0);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(4'hE, 8'hFF); rd(4'hF, v); chk("R6 clear all", v, 8'h00);
        wr(4'hA, 8'h05); rd(4'hF, v); chk("R3 set ch1", v, 8'h02);
        wr(4'hF, 8'h0C); rd(4'hF, v); chk("R6 load", v, 8'h0C);
        wr(4'hA, 8'h03); rd(4'hF, v); chk("R3 clear ch3", v, 8'h04);
    endtask

    task automatic t_request();
        logic [7:0] v;
        wr(4'h9, 8'h04); settle(); chk("R8 ch0 serviced", svc_en, 4'b0001);
        wr(4'h9, 8'h06); settle(); chk("R8 masked ch2 idle", svc_en, 4'b0001);
        rd(4'h8, v); chk("R2 request bits", v, 8'h50);
        wr(4'hA, 8'h02); settle(); chk("R8 unmask ch2", svc_en, 4'b0101);
        wr(4'h9, 8'h00); settle(); chk("R2 clear ch0 req", svc_en, 4'b0100);
    endtask

    task automatic t_hold();
        drive(0, 0, 0, 0, 4'b0010, 0, 0); settle();
        chk("R9 hold ch1", svc_en, 4'b0110);
        drive(0, 0, 0, 0, 0, 4'b0100, 0); settle();
        chk("R9 release ch2", svc_en, 4'b0010);
        drive(0, 0, 0, 0, 4'b1000, 4'b1000, 0); settle();
        chk("R9 hold beats release", svc_en, 4'b1010);
        drive(1, 0, 4'h9, 8'h00, 4'b0001, 0, 0); settle();
        chk("R9 hold beats write", svc_en, 4'b1011);
    endtask

    task automatic t_tc();
        logic [7:0] v;
        drive(0, 0, 0, 0, 0, 0, 4'b0100);
        rd(4'h8, v); chk("R10 tc set", v, 8'hB4);
        rd(4'h8, v); chk("R7 read clears tc", v, 8'hB0);
        drive(0, 0, 0, 0, 0, 0, 4'b0010);
        wr(4'h9, 8'h01);
        rd(4'h8, v); chk("R2 clears req and tc", v, 8'h90);
        drive(0, 1, 4'h8, 0, 0, 0, 4'b1000); v = rd_data;
        chk("R7 read with tc same cycle", v, 8'h90);
        rd(4'h8, v); chk("R10 tc beats read clear", v, 8'h98);
        rd(4'h8, v); chk("R7 cleared after", v, 8'h90);
    endtask

    task automatic t_pulses();
        logic [7:0] v;
        wr(4'hC, 8'h00);
        chk("R5 ff pulse", {ff_clr_pulse, mrst_pulse}, 2'b10);
        settle(); chk("R5 ff pulse one cycle", ff_clr_pulse, 0);
        drive(1, 0, 4'hD, 8'h00, 4'b0100, 0, 0);
        chk("R5 mrst pulse", {ff_clr_pulse, mrst_pulse}, 2'b01);
        settle(); chk("R5 mrst one cycle", mrst_pulse, 0);
        chk("R5 cmd cleared", cmd_word, 8'h00);
        chk("R8 all masked", svc_en, 4'b0000);
        rd(4'hF, v); chk("R5 mask all ones", v, 8'h0F);
        rd(4'h8, v); chk("R9 hold beats master reset", v, 8'h40);
        chk("R5 mode kept", mode_flat[23:16], 8'h56);
        rd(4'h9, v); chk("R7 other offset reads 0", v, 8'h00);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_command();
        t_mode();
        t_mask();
        t_request();
        t_hold();
        t_tc();
        t_pulses();
        done = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

endmodule